// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter that produces a signed three-digit decimal reading. A rate generator issues conversion starts at a fast or a slow rate. Each conversion has three phases. In the integrate phase, the current derived from the input charges the integrator for a fixed number of clocks. In the de-integrate phase, a reference current of opposite polarity discharges it while a BCD counter counts clocks. In the latch phase, the count is turned into a signed, display-ready result. The analog integrator, the reference, the comparator and the oscillator are outside the block. It sees only the comparator's "charge restored" output, a polarity bit, and its own clock.

The state machine has four states:
- `ST_IDLE`: waits for a start pulse. Transition `IDLE->INTEG` on start.
- `ST_INTEG`: enables the input current path. Transition `INTEG->DEINT` after `INT_COUNTS` clocks. On that last integrate cycle it samples the polarity input.
- `ST_DEINT`: enables the reference path and counts. Transition `DEINT->LATCH` when the comparator fires or the count reaches its signed limit.
- `ST_LATCH`: forms the result for one cycle. Transition `LATCH->IDLE` always.

The mode input selects the fast rate, the slow rate, or hold. Hold keeps converting at the slow rate but freezes the published reading.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is active, and after its release until the first start, both path enables, `done_o`, all result digits and all three flags are 0.
- R2: During each conversion, `int_en_o` is high for exactly `INT_COUNTS` consecutive clocks, and `ref_en_o` is low during those clocks.
- R3: In the clock after the last integrate clock, `int_en_o` is low and `ref_en_o` is high.
- R4: `ref_en_o` stays high for N+1 clocks, where N is the number of de-integrate clocks before the one in which `cmp_zero_i` is high. N, written as BCD digits with the most significant digit first (4 bits each), is the positive reading.
- R5: The cycle right after the latch cycle carries a `done_o` pulse exactly one clock long. The new result is valid in that cycle and is held until the next update.
- R6: `sign_neg_i` is sampled on the last integrate clock. A negative reading from 1 to 99 shows code 4'hA in the most significant digit and sets `res_neg_o`. A negative reading of zero is published as a positive 000.
- R7: If the comparator has not fired when the count is 999 on a positive conversion, de-integration ends after 1000 clocks. All digits then read 4'hB, `ovr_pos_o`=1 and `res_neg_o`=0.
- R8: If the comparator has not fired when the count is 99 on a negative conversion, de-integration ends after 100 clocks. All digits then read 4'hA, `ovr_neg_o`=1 and `res_neg_o`=1.
- R9: With mode 2'b01 (fast), integrate phases begin every `TICK_DIV*FAST_TICKS` clocks.
- R10: With mode 2'b00 (slow), integrate phases begin every `TICK_DIV*SLOW_TICKS` clocks.
- R11: With mode[1]=1 (hold), conversions continue at the slow period, but no `done_o` is raised and the result outputs do not change. Leaving hold resumes updates.
- R12: The two overrange flags are never high together, and a later in-range reading clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 slow, 01 fast, 1x hold |
| sign_neg_i | input | 1 | Input polarity is negative (sampled at the end of integrate) |
| cmp_zero_i | input | 1 | Comparator reports that the integrator charge is restored |
| int_en_o | output | 1 | Enable for the input current path |
| ref_en_o | output | 1 | Enable for the reference current path |
| done_o | output | 1 | One-clock pulse when a new result is published |
| res_neg_o | output | 1 | Published reading is negative |
| ovr_pos_o | output | 1 | Positive overrange |
| ovr_neg_o | output | 1 | Negative overrange |
| res_bcd_o | output | 4*DIGITS | Result digits, most significant digit first |

## Verification
The hardest situations to reach are the exact count boundaries: 999 against 1000 positive clocks, and 99 against 100 negative clocks. They only arise if the comparator fires in one precise de-integrate clock. The bench therefore models the comparator. It counts the cycles in which `ref_en_o` is high and raises `cmp_zero_i` in the cycle chosen by each vector. This places every boundary exactly and lets it measure the phase lengths. Hold is reached by publishing a known reading, switching the mode, and then giving the comparator a different target. The bench confirms that a full slow-period conversion leaves the outputs untouched.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INTEG,
        ST_DEINT,
        ST_LATCH
    } seq_state_t;

    localparam logic [1:0] MODE_SLOW  = 2'b00;
    localparam logic [1:0] MODE_FAST  = 2'b01;

    localparam logic [3:0] CODE_MINUS = 4'hA;
    localparam logic [3:0] CODE_OVER  = 4'hB;

endpackage

// File: rtl/dsc_rate_gen.sv
module dsc_rate_gen #(
    parameter int TICK_DIV   = 16,
    parameter int FAST_TICKS = 128,
    parameter int SLOW_TICKS = 3072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic start_o
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int TW = $clog2(SLOW_TICKS + 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] per_q;
    logic [TW-1:0] lim;
    logic          tick;

    assign lim     = fast_sel ? TW'(FAST_TICKS) : TW'(SLOW_TICKS);
    assign tick    = (pre_q == PW'(TICK_DIV - 1));
    assign start_o = tick && (per_q >= lim - TW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            per_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (per_q >= lim - TW'(1)) per_q <= '0;
            else                       per_q <= per_q + TW'(1);
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    // R9
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/dsc_bcd_cnt.sv
module dsc_bcd_cnt #(
    parameter int DIGITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  inc,
    output logic [DIGITS*4-1:0]   digits_o,
    output logic                  all9_o,
    output logic                  low9_o
);
    logic [3:0]      dig [DIGITS];
    logic [DIGITS:0] en;

    always_comb begin
        en[0] = inc;
        for (int i = 0; i < DIGITS; i++) begin
            en[i+1] = en[i] && (dig[i] == 4'd9);
        end
    end

    always_comb begin
        all9_o = 1'b1;
        low9_o = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (dig[i] != 4'd9) begin
                all9_o = 1'b0;
                if (i < DIGITS - 1) low9_o = 1'b0;
            end
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        always_ff @(posedge clk) begin
            if (!rst_n || clr)  dig[g] <= 4'd0;
            else if (en[g])     dig[g] <= (dig[g] == 4'd9) ? 4'd0 : dig[g] + 4'd1;
        end
        assign digits_o[g*4 +: 4] = dig[g];

        // R4
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dig[g] <= 4'd9);
    end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
    import dsc_pkg::*;
#(
    parameter int DIGITS     = 3,
    parameter int INT_COUNTS = 1000,
    parameter int TICK_DIV   = 16,
    parameter int FAST_TICKS = 128,
    parameter int SLOW_TICKS = 3072
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic                sign_neg_i,
    input  logic                cmp_zero_i,
    output logic                int_en_o,
    output logic                ref_en_o,
    output logic                done_o,
    output logic                res_neg_o,
    output logic                ovr_pos_o,
    output logic                ovr_neg_o,
    output logic [DIGITS*4-1:0] res_bcd_o
);
    localparam int IW = $clog2(INT_COUNTS + 1);
    localparam int RW = DIGITS * 4;

    seq_state_t    state_q, state_d;
    logic [IW-1:0] icnt_q;
    logic          neg_q, ovp_q, ovn_q;
    logic          start, hold, at_limit, integ_last, deint_end;
    logic [RW-1:0] mag;
    logic          all9, low9;
    logic [RW-1:0] val;
    logic          val_neg;

    assign hold       = mode_i[1];
    assign integ_last = (state_q == ST_INTEG) && (icnt_q == IW'(INT_COUNTS - 1));
    assign at_limit   = neg_q ? low9 : all9;
    assign deint_end  = (state_q == ST_DEINT) && (cmp_zero_i || at_limit);

    dsc_rate_gen #(
        .TICK_DIV  (TICK_DIV),
        .FAST_TICKS(FAST_TICKS),
        .SLOW_TICKS(SLOW_TICKS)
    ) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_sel(mode_i == MODE_FAST),
        .start_o (start)
    );

    dsc_bcd_cnt #(.DIGITS(DIGITS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_IDLE),
        .inc     ((state_q == ST_DEINT) && !cmp_zero_i && !at_limit),
        .digits_o(mag),
        .all9_o  (all9),
        .low9_o  (low9)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)      state_d = ST_INTEG;
            ST_INTEG: if (integ_last) state_d = ST_DEINT;
            ST_DEINT: if (deint_end)  state_d = ST_LATCH;
            ST_LATCH:                 state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // phase bookkeeping: integrate counter, sign capture, overrange capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt_q <= '0;
            neg_q  <= 1'b0;
            ovp_q  <= 1'b0;
            ovn_q  <= 1'b0;
        end else begin
            if (state_q == ST_INTEG) icnt_q <= icnt_q + IW'(1);
            else                     icnt_q <= '0;
            if (integ_last) neg_q <= sign_neg_i;
            if (state_q == ST_IDLE && start) begin
                ovp_q <= 1'b0;
                ovn_q <= 1'b0;
            end else if (deint_end && !cmp_zero_i) begin
                ovp_q <= !neg_q;
                ovn_q <= neg_q;
            end
        end
    end

    // result formatting
    always_comb begin
        if (ovp_q) begin
            val     = {DIGITS{CODE_OVER}};
            val_neg = 1'b0;
        end else if (ovn_q) begin
            val     = {DIGITS{CODE_MINUS}};
            val_neg = 1'b1;
        end else if (neg_q && (mag != '0)) begin
            val     = {CODE_MINUS, mag[RW-5:0]};
            val_neg = 1'b1;
        end else begin
            val     = mag;
            val_neg = 1'b0;
        end
    end

    // outputs
    assign int_en_o = (state_q == ST_INTEG);
    assign ref_en_o = (state_q == ST_DEINT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            res_bcd_o <= '0;
            res_neg_o <= 1'b0;
            ovr_pos_o <= 1'b0;
            ovr_neg_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_LATCH) && !hold;
            if ((state_q == ST_LATCH) && !hold) begin
                res_bcd_o <= val;
                res_neg_o <= val_neg;
                ovr_pos_o <= ovp_q;
                ovr_neg_o <= ovn_q;
            end
        end
    end

    // R2
    integ_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en_o) |-> $past(icnt_q) == IW'(INT_COUNTS - 1));

    // R3
    integ_to_deint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_en_o) |-> ref_en_o);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && state_q == ST_LATCH) |=> ($stable(res_bcd_o) && !done_o));

    // R7
    ovr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pos_o |-> (res_bcd_o == {DIGITS{CODE_OVER}}));

    // R12
    ovr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovr_pos_o && ovr_neg_o));

endmodule

// File: tb/dual_slope_seq_bench.sv
module dual_slope_seq_bench;

    localparam int INTC  = 200;
    localparam int TDIV  = 8;
    localparam int FTK   = 160;
    localparam int STK   = 480;
    localparam int NV    = 10;

    // {sign, N[10:0], digits[11:0], neg, ovp, ovn, pad[4:0]}
    localparam logic [31:0] VEC [NV] = '{
        {1'b0, 11'd0,    12'h000, 3'b000, 5'd0},
        {1'b0, 11'd5,    12'h005, 3'b000, 5'd0},
        {1'b0, 11'd437,  12'h437, 3'b000, 5'd0},
        {1'b0, 11'd999,  12'h999, 3'b000, 5'd0},
        {1'b0, 11'd1000, 12'hBBB, 3'b010, 5'd0},
        {1'b1, 11'd0,    12'h000, 3'b000, 5'd0},
        {1'b1, 11'd37,   12'hA37, 3'b100, 5'd0},
        {1'b1, 11'd99,   12'hA99, 3'b100, 5'd0},
        {1'b1, 11'd100,  12'hAAA, 3'b101, 5'd0},
        {1'b0, 11'd250,  12'h250, 3'b000, 5'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode;
    logic        sign_neg;
    logic        cmp_zero;
    logic        int_en, ref_en, done, res_neg, ovr_pos, ovr_neg;
    logic [11:0] res_bcd;

    int n_chk = 0;
    int n_bad = 0;
    int target = 0;
    int kcnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dual_slope_seq #(
        .DIGITS(3), .INT_COUNTS(INTC), .TICK_DIV(TDIV),
        .FAST_TICKS(FTK), .SLOW_TICKS(STK)
    ) u_dual_slope_seq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sign_neg_i(sign_neg),
        .cmp_zero_i(cmp_zero), .int_en_o(int_en), .ref_en_o(ref_en),
        .done_o(done), .res_neg_o(res_neg), .ovr_pos_o(ovr_pos),
        .ovr_neg_o(ovr_neg), .res_bcd_o(res_bcd)
    );

    // comparator model: fires in de-integrate clock number `target`
    always @(negedge clk) begin
        if (ref_en) begin
            cmp_zero = (kcnt == target);
            kcnt     = kcnt + 1;
        end else begin
            cmp_zero = 1'b0;
            kcnt     = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic measure_gap(output int gap, output int dn);
        while (int_en)  @(negedge clk);
        while (!int_en) @(negedge clk);
        gap = 0;
        dn  = 0;
        while (int_en)  begin @(negedge clk); gap++; if (done) dn++; end
        while (!int_en) begin @(negedge clk); gap++; if (done) dn++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int g, d, g2, d2;
        rst_n    = 1'b0;
        mode     = 2'b01;
        sign_neg = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!int_en && !ref_en && !done, "R1", {int_en, ref_en, done}, 0);
        chk(res_bcd == 12'h000 && !res_neg && !ovr_pos && !ovr_neg, "R1",
            {res_neg, ovr_pos, ovr_neg, res_bcd}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!int_en && !ref_en && !done, "R1", {int_en, ref_en, done}, 0);

        for (int i = 0; i < NV; i++) begin
            int n, lim, len, rl, explen;
            string tag;
            sign_neg = VEC[i][31];
            n        = int'(VEC[i][30:20]);
            target   = n;
            lim      = VEC[i][31] ? 99 : 999;
            explen   = ((n < lim) ? n : lim) + 1;
            if (VEC[i][6])       tag = "R7";
            else if (VEC[i][5])  tag = "R8";
            else if (VEC[i][31]) tag = "R6";
            else                 tag = "R4";
            if (i == NV - 1) tag = "R12";
            while (!int_en) @(negedge clk);
            len = 0;
            while (int_en) begin
                chk(!ref_en, "R2", ref_en, 0);
                len++;
                @(negedge clk);
            end
            chk(len == INTC, "R2", len, INTC);
            chk(ref_en, "R3", ref_en, 1);
            rl = 0;
            while (ref_en) begin rl++; @(negedge clk); end
            chk(rl == explen, tag, rl, explen);
            @(negedge clk);
            chk(done, "R5", done, 1);
            chk(res_bcd == VEC[i][19:8], tag, res_bcd, VEC[i][19:8]);
            chk({res_neg, ovr_pos, ovr_neg} == VEC[i][7:5], tag,
                {res_neg, ovr_pos, ovr_neg}, VEC[i][7:5]);
            @(negedge clk);
            chk(!done, "R5", done, 0);
            chk(res_bcd == VEC[i][19:8], "R5", res_bcd, VEC[i][19:8]);
        end

        // R9 fast period
        measure_gap(g, d);
        chk(g == TDIV * FTK, "R9", g, TDIV * FTK);

        // R10 slow period
        mode = 2'b00;
        measure_gap(g, d);
        measure_gap(g, d);
        chk(g == TDIV * STK, "R10", g, TDIV * STK);

        // R11 hold: publish 005, then freeze
        sign_neg = 1'b0;
        target   = 5;
        while (!done) @(negedge clk);
        chk(res_bcd == 12'h005, "R11", res_bcd, 12'h005);
        mode   = 2'b10;
        target = 321;
        measure_gap(g, d);
        measure_gap(g2, d2);
        chk(g2 == TDIV * STK, "R11", g2, TDIV * STK);
        chk(d + d2 == 0, "R11", d + d2, 0);
        chk(res_bcd == 12'h005 && !res_neg, "R11", res_bcd, 12'h005);
        mode = 2'b01;
        while (!done) @(negedge clk);
        chk(res_bcd == 12'h321, "R11", res_bcd, 12'h321);

        summary();
    end

endmodule